// File: doc/BRIEF.md
# Mode-Switchable SAR Phase Sequencer

This block is the digital timing core of a single-ended successive-approximation converter with 10 bits of resolution. From the system clock it advances a one-hot chain of phases: a sample phase, a settle phase, then one decision phase per bit from the most significant to the least. While a bit is under test, its DAC switch control is driven high as a trial. At the end of that phase the comparator result either keeps the bit or clears it. The resolved word leaves the block with a one-cycle valid strobe.

Two conversion lengths are available. Plain mode wraps back to sampling after the last bit decision, so a conversion takes 12 clocks. Noise-shaping mode appends four more phases, for 16 clocks in all. In that mode an integrator-connect control is held high across every bit decision, so the stored residue is injected during the conversion. One residue-transfer phase then follows the last decision, so the integration capacitors can collect the new residue.

The mode request is taken only when the chain wraps to the sample phase, so a conversion in progress keeps the length it started with. The chain runs freely: whenever no phase is active, the first phase is started.

Top module: `sar_phase_seq`

## Requirements
- R1: While reset is asserted, all phase strobes, DAC switch controls, the valid strobe, the comparator clock and both residue controls are low. After release, the first phase to become active is the sample phase (phase 0).
- R2: The `phase` vector has at most one bit set. In every conversion the phases appear in strictly increasing index order, starting from phase 0.
- R3: When no phase is active, the next clock activates phase 0.
- R4: In plain mode (mode value 0) a conversion lasts 12 clocks: phase 0 is sample, phase 1 is settle, phases 2 to 11 decide bits 9 down to 0, and phase 11 is followed by phase 0.
- R5: In noise-shaping mode (mode value 1) a conversion lasts 16 clocks. Phases 12 to 15 follow phase 11, and only then does the chain return to phase 0.
- R6: During the decision phase of bit b, `dac_sw[b]` is 1, the bits below b are 0, and the bits above b hold the earlier decisions. A decided bit is cleared when `cmp_hi` = 1 (DAC above input) at the end of its phase, and is kept otherwise. In the settle phase all DAC controls are 0.
- R7: `code_vld` is high for exactly one clock per conversion: phase 12 in noise-shaping mode, or phase 0 of the next conversion in plain mode. While it is high, `code` carries the ten decisions with bit 9 first. For a constant integer input, this equals that input.
- R8: `integ_on` is high in exactly the ten decision phases of a noise-shaping conversion, and is never high in plain mode.
- R9: `res_xfer` is high for exactly one clock, in phase 12 of a noise-shaping conversion, and is never high in plain mode.
- R10: `mode_ns` is sampled only on entry to phase 0. A change during a conversion leaves that conversion's length and controls unchanged and takes effect in the next one.
- R11: `cmp_clk` is high in exactly the ten decision phases of each conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_ns | input | 1 | Mode request: 0 plain, 1 noise-shaping |
| cmp_hi | input | 1 | Comparator result: 1 when the DAC level exceeds the held input |
| dac_sw | output | 10 | DAC bit switch controls, bit 9 most significant |
| phase | output | 16 | One-hot phase strobes, index = phase number |
| sample_ph | output | 1 | Sample phase strobe (phase 0) |
| cmp_clk | output | 1 | Comparator strobe, high in decision phases |
| integ_on | output | 1 | Connect stored-residue capacitors in series with the comparator inputs |
| res_xfer | output | 1 | Residue-transfer control (integration capacitors in parallel) |
| code | output | 10 | Resolved conversion result |
| code_vld | output | 1 | One-cycle strobe marking `code` as valid |

## Verification
The in-RTL assertions check, on every cycle, that at most one phase is active and that an empty chain restarts. They also check the wrap after phase 11 in plain mode and the continuation in noise-shaping mode, that the latched mode holds outside phase 0, that residue controls stay silent in plain mode, and that the valid strobe lasts one cycle and carries the decisions shown on the DAC controls. Only the bench's scenarios can show the following: full conversion lengths, and the cycle-by-cycle DAC trial pattern against an ideal quantiser across every input code in both modes. They also show where the residue controls fall, and that a mid-conversion mode change is deferred to the next conversion.

// File: rtl/sar_phase_seq_pkg.sv
package sar_phase_seq_pkg;

  typedef enum logic {
    MODE_SAR = 1'b0,
    MODE_NS  = 1'b1
  } conv_mode_e;

endpackage

// File: rtl/sar_phase_ring.sv
module sar_phase_ring
  import sar_phase_seq_pkg::*;
#(
  parameter int NBITS  = 10,
  parameter int NEXTRA = 4,
  localparam int NPH      = NBITS + 2 + NEXTRA,
  localparam int LAST_SAR = NBITS + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mode_req,
  output logic [NPH-1:0] ph,
  output conv_mode_e     mode_cur
);

  logic [NPH-1:0] ph_q, ph_n, shifted;
  conv_mode_e     mode_q, mode_n;
  logic           mode_en;

  // Next phase: advance the chain; tail phases are cut off in plain mode.
  always_comb begin
    shifted = {ph_q[NPH-2:0], 1'b0};
    for (int i = LAST_SAR + 1; i < NPH; i++) begin
      if (mode_q == MODE_SAR) shifted[i] = 1'b0;
    end
    ph_n = shifted;
    if (shifted == '0) ph_n[0] = 1'b1;   // empty-chain detector restarts stage 0
  end

  // Mode is captured only on entry to the sample phase.
  always_comb begin
    mode_en = ph_n[0];
    mode_n  = mode_en ? conv_mode_e'(mode_req) : mode_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      mode_q <= MODE_SAR;
    end else begin
      ph_q   <= ph_n;
      mode_q <= mode_n;
    end
  end

  assign ph       = ph_q;
  assign mode_cur = mode_q;

  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ph_q));

  p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == '0) |=> ph_q[0]);

  p_sar_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_SAR && ph_q[LAST_SAR]) |=> ph_q[0]);

  p_ns_extend_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_NS && ph_q[LAST_SAR]) |=> ph_q[LAST_SAR+1]);

  p_mode_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ph_q[0] |-> $stable(mode_q));

endmodule

// File: rtl/sar_code_reg.sv
module sar_code_reg #(
  parameter int NBITS = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_ph,
  input  logic [NBITS-1:0] bit_ph,
  input  logic             cmp_hi,
  output logic [NBITS-1:0] dac_sw,
  output logic [NBITS-1:0] code,
  output logic             code_vld
);

  logic [NBITS-1:0] dec_q, dec_n;
  logic [NBITS-1:0] code_q, code_n;
  logic             vld_q, vld_n;
  logic             lsb_done;

  // Per-bit decision storage: cleared at sample, resolved at end of own phase.
  for (genvar b = 0; b < NBITS; b++) begin : g_bit
    always_comb begin
      if (sample_ph)       dec_n[b] = 1'b0;
      else if (bit_ph[b])  dec_n[b] = ~cmp_hi;
      else                 dec_n[b] = dec_q[b];
    end
  end

  // Trial bit is raised for the whole of its decision phase.
  assign dac_sw = dec_q | bit_ph;

  always_comb begin
    lsb_done = bit_ph[0];
    vld_n    = lsb_done;
    code_n   = lsb_done ? {dec_q[NBITS-1:1], ~cmp_hi} : code_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_q  <= '0;
      code_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      dec_q <= dec_n;
      vld_q <= vld_n;
      if (lsb_done) code_q <= code_n;
    end
  end

  assign code     = code_q;
  assign code_vld = vld_q;

  p_vld_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    code_vld |=> !code_vld);

  p_code_hist_r7: assert property (@(posedge clk) disable iff (!rst_n)
    code_vld |-> (code[NBITS-1:1] == $past(dac_sw[NBITS-1:1])));

  p_settle_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sample_ph |=> (dac_sw == '0));

endmodule

// File: rtl/sar_phase_seq.sv
module sar_phase_seq
  import sar_phase_seq_pkg::*;
#(
  parameter int NBITS  = 10,
  parameter int NEXTRA = 4,
  localparam int NPH      = NBITS + 2 + NEXTRA,
  localparam int LAST_SAR = NBITS + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_ns,
  input  logic             cmp_hi,
  output logic [NBITS-1:0] dac_sw,
  output logic [NPH-1:0]   phase,
  output logic             sample_ph,
  output logic             cmp_clk,
  output logic             integ_on,
  output logic             res_xfer,
  output logic [NBITS-1:0] code,
  output logic             code_vld
);

  logic             rst_meta, rst_s;
  logic [NPH-1:0]   ph;
  conv_mode_e       mode_cur;
  logic [NBITS-1:0] bit_ph;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  sar_phase_ring #(.NBITS(NBITS), .NEXTRA(NEXTRA)) u_ring (
    .clk      (clk),
    .rst_n    (rst_s),
    .mode_req (mode_ns),
    .ph       (ph),
    .mode_cur (mode_cur)
  );

  // Bit b is decided in phase LAST_SAR-b (MSB first).
  always_comb begin
    for (int b = 0; b < NBITS; b++) bit_ph[b] = ph[LAST_SAR-b];
  end

  sar_code_reg #(.NBITS(NBITS)) u_code (
    .clk       (clk),
    .rst_n     (rst_s),
    .sample_ph (ph[0]),
    .bit_ph    (bit_ph),
    .cmp_hi    (cmp_hi),
    .dac_sw    (dac_sw),
    .code      (code),
    .code_vld  (code_vld)
  );

  assign phase     = ph;
  assign sample_ph = ph[0];
  assign cmp_clk   = |bit_ph;
  assign integ_on  = (mode_cur == MODE_NS) && cmp_clk;

  if (NEXTRA > 0) begin : g_xfer
    assign res_xfer = (mode_cur == MODE_NS) && ph[LAST_SAR+1];
  end else begin : g_no_xfer
    assign res_xfer = 1'b0;
  end

  p_sar_quiet_r8: assert property (@(posedge clk) disable iff (!rst_s)
    (mode_cur == MODE_SAR) |-> (!integ_on && !res_xfer));

  p_xfer_after_lsb_r9: assert property (@(posedge clk) disable iff (!rst_s)
    (mode_cur == MODE_NS && phase[LAST_SAR]) |=> res_xfer);

  p_vld_after_lsb_r7: assert property (@(posedge clk) disable iff (!rst_s)
    code_vld |-> $past(phase[LAST_SAR]));

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_s |-> (phase == '0 && !code_vld && !res_xfer));

endmodule

// File: tb/sar_phase_seq_bench.sv
module sar_phase_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NB  = 10;
  localparam int NPH = 16;

  logic          clk;
  logic          rst_n;
  logic          mode_ns;
  logic          cmp_hi;
  logic [NB-1:0] dac_sw;
  logic [NPH-1:0] phase;
  logic          sample_ph, cmp_clk, integ_on, res_xfer;
  logic [NB-1:0] code;
  logic          code_vld;
  logic [NB-1:0] vin;

  int checks = 0;
  int failures = 0;

  sar_phase_seq u_sar_phase_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_ns   (mode_ns),
    .cmp_hi    (cmp_hi),
    .dac_sw    (dac_sw),
    .phase     (phase),
    .sample_ph (sample_ph),
    .cmp_clk   (cmp_clk),
    .integ_on  (integ_on),
    .res_xfer  (res_xfer),
    .code      (code),
    .code_vld  (code_vld)
  );

  // Ideal comparator on a constant integer input.
  assign cmp_hi = (dac_sw > vin);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Runs one conversion; called at a falling edge with phase 0 active.
  task automatic conv(input int v, input bit flip, input int exp_len, input bit exp_ns);
    int len = 1;
    int integ_cnt = 0, xfer_cnt = 0, xfer_at = -1, cmp_cnt = 0;
    int vld_cnt = 0, got_code = -1, dac_bad = 0, ph_bad = 0;
    vin = v[NB-1:0];
    forever begin
      @(negedge clk);
      if (code_vld) begin
        vld_cnt++;
        got_code = int'(code);
      end
      if (sample_ph) break;
      len++;
      begin
        int p = len - 1;
        if (p < NPH && phase != (16'(1) << p)) ph_bad++;
        if (integ_on) integ_cnt++;
        if (res_xfer) begin xfer_cnt++; xfer_at = p; end
        if (cmp_clk) cmp_cnt++;
        if (p == 1 && dac_sw != '0) dac_bad++;
        if (p >= 2 && p <= NB + 1) begin
          int b = NB + 1 - p;
          int e = (v & ~((1 << (b + 1)) - 1)) | (1 << b);
          if (int'(dac_sw) != e) dac_bad++;
        end
        if (flip && p == 5) mode_ns = ~mode_ns;
      end
      if (len > 40) break;
    end
    check(len == exp_len, exp_ns ? "R5/R10 length" : "R4/R10 length", len, exp_len);
    check(ph_bad == 0, "R2 phase order", ph_bad, 0);
    check(dac_bad == 0, "R6 dac trial", dac_bad, 0);
    check(vld_cnt == 1, "R7 valid count", vld_cnt, 1);
    check(got_code == v, "R7 code", got_code, v);
    check(cmp_cnt == NB, "R11 cmp_clk", cmp_cnt, NB);
    check(integ_cnt == (exp_ns ? NB : 0), "R8 integ_on", integ_cnt, exp_ns ? NB : 0);
    check(xfer_cnt == (exp_ns ? 1 : 0), "R9 res_xfer count", xfer_cnt, exp_ns ? 1 : 0);
    if (exp_ns) check(xfer_at == NB + 2, "R9 res_xfer phase", xfer_at, NB + 2);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int waited;
    rst_n   = 1'b0;
    mode_ns = 1'b0;
    vin     = '0;
    repeat (3) @(negedge clk);
    // R1: quiet during reset
    check(phase == '0, "R1 phase", int'(phase), 0);
    check(dac_sw == '0 && !code_vld, "R1 dac/valid", int'(dac_sw), 0);
    check(!cmp_clk && !integ_on && !res_xfer, "R1 controls", int'(cmp_clk), 0);
    rst_n = 1'b1;
    waited = 0;
    do begin
      @(negedge clk);
      waited++;
      if (!sample_ph && phase != '0)
        check(1'b0, "R3 restart into phase 0", int'(phase), 1);
    end while (!sample_ph && waited < 10);
    check(sample_ph && waited <= 4, "R1/R3 first phase", waited, 3);

    // Plain mode: every input code
    for (int v = 0; v < (1 << NB); v++) conv(v, 1'b0, NB + 2, 1'b0);

    // R10: request at phase 0 is too late for this conversion
    mode_ns = 1'b1;
    conv(512, 1'b0, NB + 2, 1'b0);

    // Noise-shaping mode: every input code
    for (int v = 0; v < (1 << NB); v++) conv(v, 1'b0, NPH, 1'b1);

    // R10: mid-conversion changes are deferred
    conv(300, 1'b1, NPH, 1'b1);
    conv(301, 1'b0, NB + 2, 1'b0);
    conv(77, 1'b1, NB + 2, 1'b0);
    conv(78, 1'b0, NPH, 1'b1);
    conv(1023, 1'b0, NPH, 1'b1);
    conv(0, 1'b0, NPH, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule